// File: doc/BRIEF.md
# SCL Clock Timing Generator

This block sets the serial clock timing of a two-wire bus master. A first stage divides the system clock by a 7-bit prescale value. The result is a reference tick that software places near 10 MHz. A second stage counts those ticks to time the two halves of each SCL period. The upper byte of a 16-bit divider word gives the length of the high half. The lower byte gives the length of the low half. With both halves set to N, the bus runs at 5 MHz / N. The 8-bit counts span about 20 kHz to about 400 kHz, where each half is close to 13 ticks.

The block drives a phase signal, which is high while SCL should be released and low while it should be driven low. It also drives one-cycle strobes that mark each rise and each fall, for the bit engine that shifts the data. Timing starts in the released-high half. The first event after enable is therefore a fall.

The line as sensed on the bus is fed back through a synchronizer. While the block releases SCL but a slave still holds it low, the high half stops counting, so the high time is measured from the moment the line actually goes high. Dropping the enable returns the generator to its idle state at once.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and whenever enable is low, scl_phase is 1 and scl_rise and scl_fall are 0.
- R2: With enable high, a reference tick occurs once every P system clocks, where P is the prescale value, and a prescale of 0 acts as 1. Counting starts from the first clock edge at which enable is sampled high (edge index 0), and the ticks fall on edge indices P-1, 2P-1, and so on.
- R3: The high half lasts divider[15:8] reference ticks and the low half lasts divider[7:0] reference ticks.
- R4: The first event after enable rises is a fall. In the clock after the edge of the H-th tick, where H is the high count, scl_fall is 1 and scl_phase is 0. The events after that alternate rise, fall, and so on.
- R5: A value of 0 in either byte of the divider acts as a count of 1.
- R6: scl_fall is 1 only in the one clock in which scl_phase has just gone from 1 to 0. scl_rise is 1 only in the one clock in which scl_phase has just gone from 0 to 1. The two strobes are never high together.
- R7: scl_in passes through a 2-flop synchronizer. During the high half, a tick at which the synchronized line reads 0 is not counted. During the low half, scl_in has no effect.
- R8: When enable is cleared, the prescaler and half-period counters return to zero. A later enable therefore reproduces the timing of R2 to R4 from edge index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the generator while high and clears it while low |
| prescale | input | 7 | System clocks per reference tick |
| divider | input | 16 | High-half ticks in [15:8], low-half ticks in [7:0] |
| scl_in | input | 1 | SCL level as sensed on the bus |
| scl_phase | output | 1 | 1 while SCL is released, 0 while it is driven low |
| scl_rise | output | 1 | One-clock strobe marking entry to the high half |
| scl_fall | output | 1 | One-clock strobe marking entry to the low half |

## Verification
Two functions can land on the same clock edge: the end of a clock stretch, once it has crossed the synchronizer, and a reference tick. The bench holds scl_in low from before enable, then releases it so that the synchronized high appears either exactly on a tick edge or one clock before that edge. The on-edge release must not count that tick, which pushes the first fall back by a full tick period. The earlier release must count it. A third run pulls the line low only during a low half and expects the nominal timing. A scoreboard compares every strobe against the expected edge index and phase.

// File: rtl/scl_gen_pkg.sv
// Package: types shared by the SCL timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package scl_gen_pkg;

    // Level state of the generated serial clock.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    // Width of each half-period count field.
    localparam int unsigned HALF_BITS = 8;

endpackage : scl_gen_pkg

// File: rtl/scl_ref_prescaler.sv
// Module: scl_ref_prescaler
// Divides the system clock by the programmed prescale value into a
// one-clock reference tick. A prescale of zero is treated as one.
// Assumes: the enable input is synchronous to clk. The counter clears
// while enable is low, so the first tick lands on enabled edge P-1.
module scl_ref_prescaler #(
    parameter int unsigned PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);

    logic [PRE_W-1:0] div_cnt;
    logic [PRE_W-1:0] eff_div;

    // Replace a zero prescale by one, so that a tick still occurs.
    always_comb begin
        eff_div = (prescale == '0) ? PRE_W'(1) : prescale;
    end

    // Tick on the last count of each window while running.
    always_comb begin
        tick = enable && (div_cnt >= (eff_div - PRE_W'(1)));
    end

    // Window counter: hold at zero while disabled, wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + PRE_W'(1);
        end
    end

    // Two ticks in a row only when the divide ratio is one.
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eff_div > PRE_W'(1)) |=> (!tick || eff_div != $past(eff_div)))
        else $error("tick spacing broken"); // R2

    // A disabled prescaler never ticks.
    AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (div_cnt == '0))
        else $error("prescaler not cleared"); // R8

endmodule : scl_ref_prescaler

// File: rtl/scl_line_sync.sv
// Module: scl_line_sync
// Brings the sensed SCL level into the clk domain through a chain of
// flops. The chain resets to the released (high) level.
// Assumes: STAGES >= 1, and scl_in may be fully asynchronous.
module scl_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic scl_sense
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop capture of the line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= scl_in;
            end
        end else begin : g_multi
            // Shift the line level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], scl_in};
            end
        end
    endgenerate

    assign scl_sense = chain[STAGES-1];

endmodule : scl_line_sync

// File: rtl/scl_phase_engine.sv
// Module: scl_phase_engine
// Counts reference ticks through the high and low halves of SCL. It
// produces the phase level and a one-clock strobe at each change. The
// high half waits while the sensed line is low, which supports clock
// stretching.
// Assumes: tick is a one-clock pulse and scl_sense is already
// synchronous to clk.
module scl_phase_engine
    import scl_gen_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              scl_sense,
    input  logic [HALF_W-1:0] hi_count,
    input  logic [HALF_W-1:0] lo_count,
    output logic              scl_phase,
    output logic              scl_rise,
    output logic              scl_fall
);

    scl_phase_e        phase_q;
    logic [HALF_W-1:0] half_cnt;
    logic [HALF_W-1:0] hi_last;
    logic [HALF_W-1:0] lo_last;

    // Last count index of each half, with a zero count taken as one.
    always_comb begin
        hi_last = (hi_count == '0) ? '0 : hi_count - HALF_W'(1);
        lo_last = (lo_count == '0) ? '0 : lo_count - HALF_W'(1);
    end

    // Half-period sequencer: count ticks, toggle the phase, pulse a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase_q  <= PH_HIGH;
            half_cnt <= '0;
            scl_rise <= 1'b0;
            scl_fall <= 1'b0;
        end else begin
            scl_rise <= 1'b0;
            scl_fall <= 1'b0;
            if (tick) begin
                unique case (phase_q)
                    PH_HIGH: begin
                        if (!scl_sense) begin
                            half_cnt <= half_cnt;
                        end else if (half_cnt >= hi_last) begin
                            phase_q  <= PH_LOW;
                            half_cnt <= '0;
                            scl_fall <= 1'b1;
                        end else begin
                            half_cnt <= half_cnt + HALF_W'(1);
                        end
                    end
                    PH_LOW: begin
                        if (half_cnt >= lo_last) begin
                            phase_q  <= PH_HIGH;
                            half_cnt <= '0;
                            scl_rise <= 1'b1;
                        end else begin
                            half_cnt <= half_cnt + HALF_W'(1);
                        end
                    end
                    default: begin
                        phase_q  <= PH_HIGH;
                        half_cnt <= '0;
                    end
                endcase
            end
        end
    end

    assign scl_phase = (phase_q == PH_HIGH);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall))
        else $error("rise and fall together"); // R6

    AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> (!scl_phase && $past(scl_phase)))
        else $error("fall strobe without phase drop"); // R6

    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (scl_phase && !$past(scl_phase)))
        else $error("rise strobe without phase rise"); // R6

    AST_IDLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (scl_phase && !scl_rise && !scl_fall))
        else $error("not idle after disable"); // R8

    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && scl_phase && !scl_sense) |=> (scl_phase && $stable(half_cnt)))
        else $error("high half advanced while line low"); // R7

endmodule : scl_phase_engine

// File: rtl/scl_timing_gen.sv
// Module: scl_timing_gen
// Top of the SCL timing generator. The prescaler makes the reference
// tick, the line synchronizer samples the bus, and the phase engine
// times the high and low halves from the divider word.
// Assumes: divider holds the high count in its upper half and the low
// count in its lower half. The settings stay stable while enabled.
module scl_timing_gen #(
    parameter int unsigned PRE_W       = 7,
    parameter int unsigned HALF_W      = scl_gen_pkg::HALF_BITS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PRE_W-1:0]    prescale,
    input  logic [2*HALF_W-1:0] divider,
    input  logic                scl_in,
    output logic                scl_phase,
    output logic                scl_rise,
    output logic                scl_fall
);

    localparam int unsigned DIV_W = 2 * HALF_W;

    logic              ref_tick;
    logic              line_high;
    logic [HALF_W-1:0] hi_count;
    logic [HALF_W-1:0] lo_count;

    // Split the divider word into its two half-period counts.
    always_comb begin
        hi_count = divider[DIV_W-1:HALF_W];
        lo_count = divider[HALF_W-1:0];
    end

    scl_ref_prescaler #(
        .PRE_W (PRE_W)
    ) u_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .prescale (prescale),
        .tick     (ref_tick)
    );

    scl_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_line_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .scl_sense (line_high)
    );

    scl_phase_engine #(
        .HALF_W (HALF_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (ref_tick),
        .scl_sense (line_high),
        .hi_count  (hi_count),
        .lo_count  (lo_count),
        .scl_phase (scl_phase),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

endmodule : scl_timing_gen

// File: tb/scl_timing_gen_test.sv
`timescale 1ns/1ps
module scl_timing_gen_test;

    typedef struct {
        bit is_rise;
        int at;
        int req;
    } exp_ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [6:0]  prescale = '0;
    logic [15:0] divider = '0;
    logic        scl_in = 1'b1;
    logic        scl_phase;
    logic        scl_rise;
    logic        scl_fall;

    int      checks = 0;
    int      bad = 0;
    int      ecyc = 0;
    bit      prev_rise = 1'b0;
    bit      prev_fall = 1'b0;
    exp_ev_t expq[$];

    always #2.5 clk = ~clk;

    scl_timing_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .prescale  (prescale),
        .divider   (divider),
        .scl_in    (scl_in),
        .scl_phase (scl_phase),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    // Count enabled edges. Value k+1 is seen after the edge with index k.
    always @(posedge clk) begin
        if (!enable) ecyc <= 0;
        else         ecyc <= ecyc + 1;
    end

    // Monitor: pop the expected event for every strobe and compare it.
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_rise && scl_fall) begin
                checks++; bad++;
                $display("FAIL R6 both strobes high: actual=11 expected=one");
            end
            if ((scl_rise && prev_rise) || (scl_fall && prev_fall)) begin
                checks++; bad++;
                $display("FAIL R6 strobe wider than one clock: actual=2 expected=1");
            end
            if (scl_rise || scl_fall) begin
                checks++;
                if (expq.size() == 0) begin
                    bad++;
                    $display("FAIL R3 unexpected strobe rise=%0d at=%0d expected=none",
                             scl_rise, ecyc);
                end else begin
                    exp_ev_t e;
                    e = expq.pop_front();
                    if (e.is_rise != scl_rise || e.at != ecyc ||
                        scl_phase != e.is_rise) begin
                        bad++;
                        $display("FAIL R%0d event: actual rise=%0d at=%0d phase=%0d expected rise=%0d at=%0d",
                                 e.req, scl_rise, ecyc, scl_phase, e.is_rise, e.at);
                    end
                end
            end
            prev_rise = scl_rise;
            prev_fall = scl_fall;
        end
    end

    task automatic push_ev(input bit is_rise, input int at, input int req);
        exp_ev_t e;
        e.is_rise = is_rise;
        e.at = at;
        e.req = req;
        expq.push_back(e);
    endtask

    // R1/R8 idle check at the ports.
    task automatic check_idle(input string tag);
        checks++;
        if (scl_phase !== 1'b1 || scl_rise !== 1'b0 || scl_fall !== 1'b0) begin
            bad++;
            $display("FAIL %s idle: actual phase=%0d rise=%0d fall=%0d expected 1 0 0",
                     tag, scl_phase, scl_rise, scl_fall);
        end
    endtask

    task automatic finish_run(input string tag);
        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            bad++;
            $display("FAIL %s missing events: actual=%0d left expected=0", tag, expq.size());
            expq.delete();
        end
        check_idle("R8");
    endtask

    // Driver: nominal run with no stretch; events computed from R2-R5.
    task automatic run_nominal(input int p, input int hi, input int lo,
                               input int nev, input int req);
        int pe, he, le, t;
        pe = (p == 0) ? 1 : p;
        he = (hi == 0) ? 1 : hi;
        le = (lo == 0) ? 1 : lo;
        t = 0;
        for (int i = 0; i < nev; i++) begin
            if (i % 2 == 0) begin t += he * pe; push_ev(1'b0, t, req); end
            else            begin t += le * pe; push_ev(1'b1, t, req); end
        end
        @(negedge clk);
        prescale = 7'(p);
        divider  = {8'(hi), 8'(lo)};
        scl_in   = 1'b1;
        enable   = 1'b1;
        while (ecyc != t) @(negedge clk);
        enable = 1'b0;
        finish_run("R3");
    endtask

    // Driver: three events with scl_in low for enabled counts [lf, lt).
    task automatic run_line(input int p, input int hi, input int lo,
                            input int lf, input int lt,
                            input int e0, input int e1, input int e2);
        @(negedge clk);
        prescale = 7'(p);
        divider  = {8'(hi), 8'(lo)};
        scl_in   = !(lf <= 0 && 0 < lt);
        repeat (4) @(negedge clk);
        push_ev(1'b0, e0, 7);
        push_ev(1'b1, e1, 7);
        push_ev(1'b0, e2, 7);
        enable = 1'b1;
        @(negedge clk);
        while (ecyc != e2) begin
            scl_in = !(lf <= ecyc && ecyc < lt);
            @(negedge clk);
        end
        enable = 1'b0;
        scl_in = 1'b1;
        finish_run("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");                      // R1 in reset
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1");                      // R1 after reset, disabled

        run_nominal(3, 5, 4, 6, 3);            // R2 R3 R4
        run_nominal(5, 2, 7, 5, 3);            // R3 uneven halves
        run_nominal(1, 13, 13, 4, 4);          // R4 fast-rate count
        run_nominal(0, 0, 0, 8, 5);            // R5 all zero, R6 back to back
        run_nominal(1, 3, 0, 6, 5);            // R5 zero low half

        // R8: partial run, then restart from zero.
        @(negedge clk);
        prescale = 7'd3; divider = 16'h0504; enable = 1'b1;
        repeat (7) @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R8");
        run_nominal(3, 5, 4, 4, 8);            // R8 timing from edge 0

        // R7: release seen on the tick edge itself is not counted.
        run_line(4, 3, 2, 0, 10, 24, 32, 44);
        // R7: release one clock earlier counts that tick.
        run_line(4, 3, 2, 0, 9, 20, 28, 40);
        // R7: a low line during the low half has no effect.
        run_line(2, 2, 3, 4, 8, 4, 10, 14);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5 * 100000);
        checks++; bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule : scl_timing_gen_test